// File: doc/BRIEF.md
# Three-wire panel register writer

This block performs a single register write into a display panel over a write-only serial link of three wires: an active-low select, a clock and a data line. A requester presents an 8-bit register address and an 8-bit value together with a one-cycle start strobe. The block turns them into a 16-bit word and shifts it out, most significant bit first. The line timing is slow and expressed in microseconds: a setup delay after select falls, equal low and high clock phases per bit, and a guard interval after select rises.

An optional shaping mode can be chosen for each request. In this mode the address is turned into a command byte before it is sent, and a further pause is added after the guard interval. The block raises busy for the whole transaction and pulses done when it can accept the next request. The four delays are parameters in microseconds. They are converted to clock cycles from a clock-frequency parameter.

Top module: `tw_panel_writer`

## Requirements
- R1: Out of reset and between transactions, the link idles with select high, clock high and data low, and busy and done are low.
- R2: The word sent holds the (possibly shaped) address in bits 15:8 and the value in bits 7:0. It is sent most significant bit first, and the panel takes each bit on a rising clock edge, 16 bits per transaction.
- R3: A start strobe seen while idle drops select on the next cycle. Select then stays low with the clock high for SETUP cycles before the first clock fall.
- R4: Each bit holds the clock low for HALF cycles and then high for HALF cycles. Data changes only together with a clock fall and stays steady while the clock is high.
- R5: HALF cycles after the 16th rising edge, select returns high and data returns low. Busy then stays high for GUARD more cycles.
- R6: When shape_i is high at acceptance, the address byte sent is (addr << 2) | 2 truncated to 8 bits, and PAUSE extra busy cycles follow the guard. Address, value and shape are captured only at acceptance.
- R7: Busy is high from the cycle after acceptance until the transaction ends. Done is high for exactly one cycle, the first cycle in which busy is low again.
- R8: A start strobe given while busy is ignored: the word sent, every phase length and the end of the transaction are unchanged.
- R9: Each delay in cycles equals (CLK_FREQ_HZ / 1,000,000) times its microsecond parameter.
- R10: Asserting rst_ni in the middle of a transaction puts the link at idle levels at once, and the next request runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| shape_i | input | 1 | Select address shaping for this request |
| addr_i | input | 8 | Register address |
| data_i | input | 8 | Register value |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| link_en_no | output | 1 | Link select, active low |
| link_clk_o | output | 1 | Link clock, idles high |
| link_dat_o | output | 1 | Link data, idles low |

## Verification
The serial word is tried with all-ones against all-zeros bytes, alternating bit patterns, and seeded random address and value pairs. Each pattern is sent in both plain and shaped mode, so a swapped byte order, a reversed bit order or a missing shift shows up as a different captured word. An all-ones address in shaped mode shows whether the top address bits are truncated, and toggling shape_i after acceptance shows whether it is captured only at acceptance. Strobes given during the bit phase and during the guard phase separate a block that ignores them from one that restarts or changes its word, and a reset in the middle of a frame shows whether the link goes back to idle and starts cleanly on the next request.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_GUARD,
    ST_PAUSE
  } tw_state_e;

  localparam int SHAPE_SHIFT = 2;
  localparam int SHAPE_OR    = 2;
  localparam int HZ_PER_MHZ  = 1_000_000;
endpackage

// File: rtl/tw_frame_builder.sv
module tw_frame_builder #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               shape_i,
  output logic [FRAME_W-1:0] frame_o
);
  import tw_pkg::*;

  logic [ADDR_W-1:0] shaped_addr;
  logic [ADDR_W-1:0] sel_addr;

  assign shaped_addr = (addr_i << SHAPE_SHIFT) | ADDR_W'(SHAPE_OR);
  assign sel_addr    = shape_i ? shaped_addr : addr_i;
  assign frame_o     = {sel_addr, data_i};
endmodule

// File: rtl/tw_delay_timer.sv
module tw_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  // load N, expire N cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i - CNT_W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  a_r9_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (load_val_i != '0));
endmodule

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter #(
  parameter int FRAME_W = 16,
  localparam int CW = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               shift_i,
  output logic               cur_bit_o,
  output logic               nxt_bit_o,
  output logic               last_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cur_bit_o = sh_q[FRAME_W-1];
  assign nxt_bit_o = sh_q[FRAME_W-2];
  assign last_o    = (cnt_q == LAST);

  a_r2_no_shift_past_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (cnt_q != LAST));
  a_r2_load_clears_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0));
endmodule

// File: rtl/tw_panel_writer.sv
module tw_panel_writer #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int SETUP_US    = 25,
  parameter int HALF_US     = 25,
  parameter int GUARD_US    = 100,
  parameter int PAUSE_US    = 100,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              shape_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              link_en_no,
  output logic              link_clk_o,
  output logic              link_dat_o
);
  import tw_pkg::*;

  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int CYC_US    = CLK_FREQ_HZ / HZ_PER_MHZ;
  localparam int SETUP_CYC = CYC_US * SETUP_US;
  localparam int HALF_CYC  = CYC_US * HALF_US;
  localparam int GUARD_CYC = CYC_US * GUARD_US;
  localparam int PAUSE_CYC = CYC_US * PAUSE_US;
  localparam int MAX_AB    = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int MAX_CD    = (GUARD_CYC > PAUSE_CYC) ? GUARD_CYC : PAUSE_CYC;
  localparam int MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_V = CNT_W'(SETUP_CYC);
  localparam logic [CNT_W-1:0] HALF_V  = CNT_W'(HALF_CYC);
  localparam logic [CNT_W-1:0] GUARD_V = CNT_W'(GUARD_CYC);
  localparam logic [CNT_W-1:0] PAUSE_V = CNT_W'(PAUSE_CYC);

  tw_state_e state_q, state_d;
  logic en_q, en_d, clk_q, clk_d, dat_q, dat_d;
  logic busy_q, busy_d, done_q, done_d, shape_q, shape_d;
  logic tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic sh_load, sh_shift, cur_bit, nxt_bit, last_bit;
  logic [FRAME_W-1:0] frame;

  tw_frame_builder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
    .addr_i (addr_i),
    .data_i (data_i),
    .shape_i(shape_i),
    .frame_o(frame)
  );

  tw_delay_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .expired_o (tmr_exp)
  );

  tw_bit_shifter #(.FRAME_W(FRAME_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sh_load),
    .frame_i  (frame),
    .shift_i  (sh_shift),
    .cur_bit_o(cur_bit),
    .nxt_bit_o(nxt_bit),
    .last_o   (last_bit)
  );

  always_comb begin
    state_d  = state_q;
    en_d     = en_q;
    clk_d    = clk_q;
    dat_d    = dat_q;
    busy_d   = busy_q;
    done_d   = 1'b0;
    shape_d  = shape_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_SETUP;
        en_d     = 1'b0;
        busy_d   = 1'b1;
        shape_d  = shape_i;
        sh_load  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = SETUP_V;
      end
      ST_SETUP: if (tmr_exp) begin
        state_d  = ST_BIT_LO;
        clk_d    = 1'b0;
        dat_d    = cur_bit;
        tmr_load = 1'b1;
        tmr_val  = HALF_V;
      end
      ST_BIT_LO: if (tmr_exp) begin
        state_d  = ST_BIT_HI;
        clk_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = HALF_V;
      end
      ST_BIT_HI: if (tmr_exp) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          state_d = ST_GUARD;
          en_d    = 1'b1;
          dat_d   = 1'b0;
          tmr_val = GUARD_V;
        end else begin
          state_d  = ST_BIT_LO;
          clk_d    = 1'b0;
          dat_d    = nxt_bit;
          sh_shift = 1'b1;
          tmr_val  = HALF_V;
        end
      end
      ST_GUARD: if (tmr_exp) begin
        if (shape_q) begin
          state_d  = ST_PAUSE;
          tmr_load = 1'b1;
          tmr_val  = PAUSE_V;
        end else begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      ST_PAUSE: if (tmr_exp) begin
        state_d = ST_IDLE;
        busy_d  = 1'b0;
        done_d  = 1'b1;
      end
      default: begin
        state_d = ST_IDLE;
        en_d    = 1'b1;
        clk_d   = 1'b1;
        dat_d   = 1'b0;
        busy_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b1;
      clk_q   <= 1'b1;
      dat_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      shape_q <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      clk_q   <= clk_d;
      dat_q   <= dat_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      shape_q <= shape_d;
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign link_en_no = en_q;
  assign link_clk_o = clk_q;
  assign link_dat_o = dat_q;

  a_r1_idle_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (en_q && clk_q && !dat_q && !busy_q));
  a_r3_select_falls_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_q) |-> ($past(start_i) && !$past(busy_q)));
  a_r4_data_steady_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && clk_q && $past(!en_q) && $past(clk_q)) |-> $stable(dat_q));
  a_r5_select_rises_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> (clk_q && !dat_q && busy_q));
  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r7_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));
  a_r8_busy_holds_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !en_q) |=> busy_q);
endmodule

// File: tb/test_tw_panel_writer.sv
`timescale 1ns/1ps
module test_tw_panel_writer;
  localparam int P_CLK   = 2_000_000;
  localparam int P_SETUP = 3;
  localparam int P_HALF  = 5;
  localparam int P_GUARD = 7;
  localparam int P_PAUSE = 11;
  localparam int E_CU    = P_CLK / 1_000_000;
  localparam int E_SETUP = E_CU * P_SETUP;
  localparam int E_HALF  = E_CU * P_HALF;
  localparam int E_GUARD = E_CU * P_GUARD;
  localparam int E_PAUSE = E_CU * P_PAUSE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, shape = 1'b0;
  logic [7:0] addr = '0, data = '0;
  logic busy, done, en_n, sclk, sdat;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tw_panel_writer #(
    .CLK_FREQ_HZ(P_CLK), .SETUP_US(P_SETUP), .HALF_US(P_HALF),
    .GUARD_US(P_GUARD), .PAUSE_US(P_PAUSE), .ADDR_W(8), .DATA_W(8)
  ) i_tw_panel_writer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shape_i(shape),
    .addr_i(addr), .data_i(data), .busy_o(busy), .done_o(done),
    .link_en_no(en_n), .link_clk_o(sclk), .link_dat_o(sdat)
  );

  function automatic logic [15:0] exp_word(input logic [7:0] a, input logic [7:0] d, input logic sh);
    logic [7:0] ab;
    ab = sh ? {a[5:0], 2'b10} : a;
    return {ab, d};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " select"}, int'(en_n), 1);
    chk({req, " clock"}, int'(sclk), 1);
    chk({req, " data"}, int'(sdat), 0);
    chk({req, " busy"}, int'(busy), 0);
  endtask

  // poke: 0 none, 1 strobe during bits, 2 strobe during guard
  task automatic run_frame(input logic [7:0] a, input logic [7:0] d, input logic sh, input int poke);
    logic pc, pe, pd, seen, ended, poked;
    int setup_n, lo_n, hi_n, guard_n, nbits, bad_lo, bad_hi, bad_dat, bad_grd;
    logic [15:0] got;
    pc = 1; pe = 0; pd = 0; seen = 0; ended = 0; poked = 0;
    setup_n = 0; lo_n = 0; hi_n = 0; guard_n = 0; nbits = 0;
    bad_lo = 0; bad_hi = 0; bad_dat = 0; bad_grd = 0; got = '0;
    @(negedge clk);
    addr = a; data = d; shape = sh; start = 1'b1;
    @(negedge clk);
    start = 1'b0; addr = ~a; data = ~d; shape = ~sh;
    chk("R7 busy after accept", int'(busy), 1);
    chk("R3 select low after accept", int'(en_n), 0);
    for (int n = 0; n < 5000 && !ended; n++) begin
      if (n > 0) @(negedge clk);
      start = 1'b0;
      if (!en_n) begin
        if (!seen && sclk) setup_n++;
        if (sclk && !pc) begin
          got = {got[14:0], sdat};
          nbits++;
          if (lo_n != E_HALF) bad_lo++;
          lo_n = 0;
        end
        if (!sclk && pc && seen) begin
          if (hi_n != E_HALF) bad_hi++;
          hi_n = 0;
        end
        if (sclk && pc && sdat != pd) bad_dat++;
        if (!sclk) begin lo_n++; seen = 1; end
        else if (seen) hi_n++;
        if (poke == 1 && nbits == 5 && !poked) begin
          start = 1'b1; addr = a ^ 8'h5A; data = d ^ 8'hC3; poked = 1;
        end
      end else if (busy) begin
        if (!pe && hi_n != E_HALF) bad_hi++;
        if (!sclk || sdat) bad_grd++;
        guard_n++;
        if (poke == 2 && guard_n == 3 && !poked) begin
          start = 1'b1; addr = a ^ 8'hFF; poked = 1;
        end
      end else begin
        ended = 1;
        chk("R7 done at end", int'(done), 1);
        chk_idle("R1 after frame");
      end
      pc = sclk; pe = en_n; pd = sdat;
    end
    chk("R7 transaction ended", int'(ended), 1);
    chk("R2 bit count", nbits, 16);
    chk("R2 R6 word", int'(got), int'(exp_word(a, d, sh)));
    chk("R3 R9 setup cycles", setup_n, E_SETUP);
    chk("R4 low phase errors", bad_lo, 0);
    chk("R4 high phase errors", bad_hi, 0);
    chk("R4 data change while clock high", bad_dat, 0);
    chk("R5 guard line levels", bad_grd, 0);
    chk("R5 R6 guard cycles", guard_n, sh ? E_GUARD + E_PAUSE : E_GUARD);
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);
    chk("R8 no restart", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1A2B);
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 after reset");

    run_frame(8'hFF, 8'h00, 1'b0, 0);
    run_frame(8'h00, 8'hFF, 1'b0, 0);
    run_frame(8'hA5, 8'h5A, 1'b0, 0);
    run_frame(8'hFF, 8'h81, 1'b1, 0);   // R6 truncation of shaped address
    run_frame(8'h3F, 8'h01, 1'b1, 0);
    run_frame(8'h12, 8'h34, 1'b0, 1);   // R8 strobe during bits
    run_frame(8'h56, 8'h78, 1'b1, 2);   // R8 strobe during guard

    // R10 reset mid-frame
    @(negedge clk);
    addr = 8'hC3; data = 8'h3C; shape = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R10 reset mid-frame");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 after release");
    run_frame(8'h9E, 8'h47, 1'b0, 0);

    for (int i = 0; i < 30; i++) begin
      logic [7:0] ra, rd;
      logic rs;
      int rp;
      ra = 8'($urandom);
      rd = 8'($urandom);
      rs = 1'($urandom);
      rp = int'($urandom % 3);
      run_frame(ra, rd, rs, rp);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule